// File: doc/BRIEF.md
# Switching Lattice Path Evaluator

This block evaluates a rectangular grid of four-terminal switches. Each site carries a literal code that picks one input variable, its complement, or a fixed level. On a start pulse the block captures the grid codes and the input vector and works out which sites conduct. It then floods connectivity outward, one neighbour step per clock, from two seed edges at once. The first question is whether a chain of conducting sites links the upper edge to the lower edge. The second is whether a chain links the leftmost column to the rightmost column.

A grid holds a function in its vertical paths and the dual of that function in its horizontal paths. Both answers come out together, with a one-cycle done pulse. Conduction runs through shared edges only, never through corners, so connectivity is a property of the whole grid. It is not a fixed sum of products. The grid is ROWS by COLS sites, 3 by 3 by default. Software or a test harness loads the codes in parallel, pulses start, and reads the two result bits once done is seen.

Top module: `switch_lattice_eval`

## Requirements
- R1: Site (r,c) uses the CODE_W-bit field lit_codes[(r*COLS+c)*CODE_W +: CODE_W]. Bit 0 of the field is the polarity, where 1 inverts the variable. The remaining bits are the variable index into var_in. The all-ones code is always off and the all-ones code minus one is always on. Any other index at or above NVARS makes the site off. With the defaults (CODE_W=4, NVARS=4), code 2*i selects var_in[i], 2*i+1 selects its inverse, 14 is on, 15 is off, and 8 through 13 are off.
- R2: A conducting site links only to the conducting sites that share an edge with it (up, down, left, right). Two sites that touch at a corner only are not linked.
- R3: top_bottom is 1 exactly when a chain of conducting sites joins a site of row 0 to a site of row ROWS-1.
- R4: left_right is 1 exactly when a chain of conducting sites joins a site of column 0 to a site of column COLS-1.
- R5: done is high for exactly one cycle per accepted start. Take the two masks, each seeded with the conducting sites on its own seed edge, and grow them in lockstep one neighbour step per cycle. done is seen on the k-th clock edge after the edge that accepts start, where k is the first step at which neither mask grows. k never exceeds ROWS*COLS.
- R6: top_bottom and left_right are 0 after reset. They change only in the cycle in which done is high, and they hold in between even if the inputs move.
- R7: lit_codes and var_in are sampled only at the edge that accepts start. A start that arrives while an evaluation is running is ignored: it does not change the result and produces no extra done. A start that is high in the cycle where done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation (taken when idle) |
| lit_codes | input | ROWS*COLS*CODE_W | Literal code for every site, row-major |
| var_in | input | NVARS | Input variable vector |
| done | output | 1 | One-cycle pulse when the results are updated |
| top_bottom | output | 1 | A vertical conducting chain exists |
| left_right | output | 1 | A horizontal conducting chain exists |

## Verification
The block goes idle on the same edge that raises done, so a finishing evaluation and the acceptance of the next start can fall in the same cycle. The bench holds start high during the done cycle of a slow serpentine grid and loads a new all-off grid at that moment. It then expects three things: the old results still visible one cycle later with done low, the new results together with a fresh done on the following cycle, and no second pulse. A separate case raises start in the middle of a running evaluation and expects the original result, the original latency and no extra done.

// File: rtl/lattice_pkg.sv
package lattice_pkg;

   typedef enum logic {
      LAT_IDLE = 1'b0,
      LAT_RUN  = 1'b1
   } lat_state_e;

   // polarity bit plus an index wide enough that the top index value is
   // left free for the two constant codes
   function automatic int lat_code_width(input int nvars);
      return $clog2(nvars + 1) + 1;
   endfunction

endpackage

// File: rtl/lat_site_decode.sv
module lat_site_decode #(
   parameter int NVARS  = 4,
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code,
   input  logic [NVARS-1:0]  var_in,
   output logic              site_on
);
   localparam int IDX_W = CODE_W - 1;
   localparam logic [CODE_W-1:0] CODE_OFF = '1;
   localparam logic [CODE_W-1:0] CODE_ON  = {{IDX_W{1'b1}}, 1'b0};

   logic [IDX_W-1:0] idx;
   logic             sel;
   logic             hit;

   assign idx = code[CODE_W-1:1];

   always_comb begin
      sel = 1'b0;
      hit = 1'b0;
      for (int i = 0; i < NVARS; i++) begin
         if (idx == IDX_W'(i)) begin
            sel = var_in[i];
            hit = 1'b1;
         end
      end
   end

   always_comb begin
      if (code == CODE_OFF)
         site_on = 1'b0;
      else if (code == CODE_ON)
         site_on = 1'b1;
      else if (hit)
         site_on = sel ^ code[0];
      else
         site_on = 1'b0;
   end
endmodule

// File: rtl/lat_flood_step.sv
module lat_flood_step #(
   parameter int ROWS = 3,
   parameter int COLS = 3
) (
   input  logic [ROWS*COLS-1:0] site_on,
   input  logic [ROWS*COLS-1:0] reach_cur,
   output logic [ROWS*COLS-1:0] reach_nxt
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int I = r*COLS + c;
         logic from_up, from_dn, from_lf, from_rt;

         if (r > 0) begin : g_up
            assign from_up = reach_cur[I-COLS];
         end else begin : g_no_up
            assign from_up = 1'b0;
         end

         if (r < ROWS-1) begin : g_dn
            assign from_dn = reach_cur[I+COLS];
         end else begin : g_no_dn
            assign from_dn = 1'b0;
         end

         if (c > 0) begin : g_lf
            assign from_lf = reach_cur[I-1];
         end else begin : g_no_lf
            assign from_lf = 1'b0;
         end

         if (c < COLS-1) begin : g_rt
            assign from_rt = reach_cur[I+1];
         end else begin : g_no_rt
            assign from_rt = 1'b0;
         end

         assign reach_nxt[I] = reach_cur[I] |
                               (site_on[I] & (from_up | from_dn | from_lf | from_rt));
      end
   end
endmodule

// File: rtl/lat_sequencer.sv
module lat_sequencer
   import lattice_pkg::*;
#(
   parameter int CAP   = 9,
   parameter int CNT_W = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             settled,
   output logic             load,
   output logic             advance,
   output logic             finish,
   output logic             running,
   output logic [CNT_W-1:0] step_cnt
);
   lat_state_e state_q;
   logic       at_cap;

   assign running = (state_q == LAT_RUN);
   assign at_cap  = (step_cnt == CNT_W'(CAP - 1));
   assign load    = start && (state_q == LAT_IDLE);
   assign finish  = running && (settled || at_cap);
   assign advance = running && !finish;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= LAT_IDLE;
         step_cnt <= '0;
      end else if (load) begin
         state_q  <= LAT_RUN;
         step_cnt <= '0;
      end else if (finish) begin
         state_q  <= LAT_IDLE;
      end else if (advance) begin
         step_cnt <= step_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/switch_lattice_eval.sv
module switch_lattice_eval
   import lattice_pkg::*;
#(
   parameter int ROWS   = 3,
   parameter int COLS   = 3,
   parameter int NVARS  = 4,
   parameter int CODE_W = lat_code_width(NVARS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [ROWS*COLS*CODE_W-1:0] lit_codes,
   input  logic [NVARS-1:0]            var_in,
   output logic                        done,
   output logic                        top_bottom,
   output logic                        left_right
);
   localparam int SITES = ROWS * COLS;
   localparam int CAP   = SITES;
   localparam int CNT_W = $clog2(CAP + 1);

   if (ROWS < 1 || COLS < 1) begin : g_bad_shape
      $error("lattice needs at least one row and one column");
   end
   if (NVARS < 1) begin : g_bad_vars
      $error("lattice needs at least one input variable");
   end
   if (CODE_W < lat_code_width(NVARS)) begin : g_bad_code
      $error("CODE_W too narrow for NVARS plus the two constant codes");
   end

   logic [SITES-1:0] on_w, on_q;
   logic [SITES-1:0] vseed, hseed;
   logic [SITES-1:0] vmask, hmask;
   logic [SITES-1:0] vnext, hnext;
   logic [COLS-1:0]  bottom_bits;
   logic [ROWS-1:0]  right_bits;
   logic             settled, load, advance, finish, running;
   logic [CNT_W-1:0] step_cnt;

   for (genvar s = 0; s < SITES; s++) begin : g_site
      lat_site_decode #(.NVARS(NVARS), .CODE_W(CODE_W)) u_dec (
         .code    (lit_codes[s*CODE_W +: CODE_W]),
         .var_in  (var_in),
         .site_on (on_w[s])
      );
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_seed_r
      for (genvar c = 0; c < COLS; c++) begin : g_seed_c
         if (r == 0) begin : g_vs
            assign vseed[r*COLS+c] = on_w[r*COLS+c];
         end else begin : g_vz
            assign vseed[r*COLS+c] = 1'b0;
         end
         if (c == 0) begin : g_hs
            assign hseed[r*COLS+c] = on_w[r*COLS+c];
         end else begin : g_hz
            assign hseed[r*COLS+c] = 1'b0;
         end
      end
   end

   lat_flood_step #(.ROWS(ROWS), .COLS(COLS)) u_vstep (
      .site_on   (on_q),
      .reach_cur (vmask),
      .reach_nxt (vnext)
   );

   lat_flood_step #(.ROWS(ROWS), .COLS(COLS)) u_hstep (
      .site_on   (on_q),
      .reach_cur (hmask),
      .reach_nxt (hnext)
   );

   for (genvar c = 0; c < COLS; c++) begin : g_bot
      assign bottom_bits[c] = vnext[(ROWS-1)*COLS + c];
   end
   for (genvar r = 0; r < ROWS; r++) begin : g_right
      assign right_bits[r] = hnext[r*COLS + COLS - 1];
   end

   assign settled = (vnext == vmask) && (hnext == hmask);

   lat_sequencer #(.CAP(CAP), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .settled  (settled),
      .load     (load),
      .advance  (advance),
      .finish   (finish),
      .running  (running),
      .step_cnt (step_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q       <= '0;
         vmask      <= '0;
         hmask      <= '0;
         done       <= 1'b0;
         top_bottom <= 1'b0;
         left_right <= 1'b0;
      end else begin
         done <= finish;
         if (load) begin
            on_q  <= on_w;
            vmask <= vseed;
            hmask <= hseed;
         end else if (advance || finish) begin
            vmask <= vnext;
            hmask <= hnext;
         end
         if (finish) begin
            top_bottom <= |bottom_bits;
            left_right <= |right_bits;
         end
      end
   end
endmodule

// File: rtl/lat_eval_checker.sv
module lat_eval_checker #(
   parameter int ROWS  = 3,
   parameter int COLS  = 3,
   parameter int CAP   = ROWS * COLS,
   parameter int CNT_W = $clog2(CAP + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 done,
   input logic                 top_bottom,
   input logic                 left_right,
   input logic                 running,
   input logic [ROWS*COLS-1:0] on_q,
   input logic [ROWS*COLS-1:0] vmask,
   input logic [ROWS*COLS-1:0] hmask,
   input logic [CNT_W-1:0]     step_cnt
);
   logic bot_any, right_any;

   always_comb begin
      bot_any = 1'b0;
      for (int c = 0; c < COLS; c++) bot_any |= vmask[(ROWS-1)*COLS + c];
      right_any = 1'b0;
      for (int r = 0; r < ROWS; r++) right_any |= hmask[r*COLS + COLS - 1];
   end

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (step_cnt < CNT_W'(CAP)));

   assert_hold_results_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(top_bottom) && $stable(left_right)));

   assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start) |=> $stable(on_q));

   assert_vmask_on_sites_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vmask & ~on_q) == '0);

   assert_hmask_on_sites_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hmask & ~on_q) == '0);

   assert_vmask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> ((vmask & $past(vmask)) == $past(vmask)));

   assert_vresult_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (top_bottom == bot_any));

   assert_hresult_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (left_right == right_any));
endmodule

bind switch_lattice_eval lat_eval_checker #(.ROWS(ROWS), .COLS(COLS)) u_lat_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .done       (done),
   .top_bottom (top_bottom),
   .left_right (left_right),
   .running    (running),
   .on_q       (on_q),
   .vmask      (vmask),
   .hmask      (hmask),
   .step_cnt   (step_cnt)
);

// File: tb/tb_switch_lattice_eval.sv
module tb_switch_lattice_eval;
   localparam int R  = 3;
   localparam int C  = 3;
   localparam int NV = 4;
   localparam int LW = 4;
   localparam int N  = R * C;
   localparam int NB = N * LW;
   localparam logic [LW-1:0] K_ON  = 4'd14;
   localparam logic [LW-1:0] K_OFF = 4'd15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NB-1:0] lit_codes = '0;
   logic [NV-1:0] var_in = '0;
   logic          done, top_bottom, left_right;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   switch_lattice_eval #(.ROWS(R), .COLS(C), .NVARS(NV), .CODE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .lit_codes(lit_codes),
      .var_in(var_in), .done(done), .top_bottom(top_bottom), .left_right(left_right)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit site_level(input logic [LW-1:0] code, input logic [NV-1:0] vv);
      int idx;
      if (code == K_OFF) return 1'b0;
      if (code == K_ON)  return 1'b1;
      idx = int'(code) / 2;
      if (idx >= NV) return 1'b0;
      return vv[idx] ^ code[0];
   endfunction

   function automatic logic [NB-1:0] fill(input logic [LW-1:0] code);
      logic [NB-1:0] l;
      for (int s = 0; s < N; s++) l[s*LW +: LW] = code;
      return l;
   endfunction

   function automatic logic [NB-1:0] put(input logic [NB-1:0] l, input int r,
                                         input int c, input logic [LW-1:0] code);
      logic [NB-1:0] o;
      o = l;
      o[(r*C+c)*LW +: LW] = code;
      return o;
   endfunction

   // reference: grow both masks in lockstep, count steps to the first idle step
   task automatic model(input logic [NB-1:0] l, input logic [NV-1:0] vv,
                        output bit f, output bit g, output int lat);
      bit on[N];
      bit vm[N], hm[N], vn[N], hn[N];
      bit same;
      for (int s = 0; s < N; s++) begin
         on[s] = site_level(l[s*LW +: LW], vv);
         vm[s] = on[s] && (s / C == 0);
         hm[s] = on[s] && (s % C == 0);
      end
      lat = 0;
      forever begin
         lat++;
         same = 1'b1;
         for (int s = 0; s < N; s++) begin
            int r = s / C;
            int c = s % C;
            bit vnb = (r > 0 && vm[s-C]) || (r < R-1 && vm[s+C]) ||
                      (c > 0 && vm[s-1]) || (c < C-1 && vm[s+1]);
            bit hnb = (r > 0 && hm[s-C]) || (r < R-1 && hm[s+C]) ||
                      (c > 0 && hm[s-1]) || (c < C-1 && hm[s+1]);
            vn[s] = vm[s] || (on[s] && vnb);
            hn[s] = hm[s] || (on[s] && hnb);
            if (vn[s] != vm[s] || hn[s] != hm[s]) same = 1'b0;
         end
         vm = vn;
         hm = hn;
         if (same || lat >= N) break;
      end
      f = 1'b0;
      g = 1'b0;
      for (int c = 0; c < C; c++) f |= vm[(R-1)*C + c];
      for (int r = 0; r < R; r++) g |= hm[r*C + C - 1];
   endtask

   task automatic wait_done(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (done || n >= 3*N) break;
      end
   endtask

   task automatic run_case(input logic [NB-1:0] l, input logic [NV-1:0] vv,
                           input string rq_f, input string rq_g);
      bit ef, eg;
      int el, n;
      model(l, vv, ef, eg, el);
      @(negedge clk);
      lit_codes = l;
      var_in    = vv;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(n);
      check(done == 1'b1, "R5", "done seen", int'(done), 1);
      check(n == el, "R5", "latency", n, el);
      check(top_bottom == ef, rq_f, "top_bottom", int'(top_bottom), int'(ef));
      check(left_right == eg, rq_g, "left_right", int'(left_right), int'(eg));
      @(negedge clk);
      check(done == 1'b0, "R5", "done single pulse", int'(done), 0);
   endtask

   logic [NB-1:0] snake;

   initial begin
      void'($urandom(32'h5EED_1A77));

      repeat (3) @(negedge clk);
      check(done == 1'b0, "R6", "reset done", int'(done), 0);
      check(top_bottom == 1'b0, "R6", "reset top_bottom", int'(top_bottom), 0);
      check(left_right == 1'b0, "R6", "reset left_right", int'(left_right), 0);
      rst_n = 1'b1;

      // constants (R1)
      run_case(fill(K_ON), '0, "R1", "R1");
      run_case(fill(K_OFF), '1, "R1", "R1");

      // corner-only contact does not conduct (R2)
      begin
         logic [NB-1:0] d;
         d = fill(K_OFF);
         for (int k = 0; k < R; k++) d = put(d, k, k, K_ON);
         run_case(d, '0, "R2", "R2");
         // staircase with an edge bridge conducts both ways
         d = put(d, 0, 1, K_ON);
         d = put(d, 1, 2, K_ON);
         run_case(d, '0, "R2", "R2");
      end

      // middle column only: vertical yes, horizontal no (R3)
      begin
         logic [NB-1:0] d;
         d = fill(K_OFF);
         for (int k = 0; k < R; k++) d = put(d, k, 1, K_ON);
         run_case(d, '0, "R3", "R4");
         d = fill(K_OFF);
         for (int k = 0; k < C; k++) d = put(d, 1, k, K_ON);
         run_case(d, '0, "R3", "R4");
      end

      // literal decode through a centre column (R1)
      begin
         logic [NB-1:0] d;
         d = fill(K_OFF);
         for (int k = 0; k < R; k++) d = put(d, k, 1, 4'd4);   // var_in[2]
         run_case(d, 4'b0100, "R1", "R1");
         run_case(d, 4'b1011, "R1", "R1");
         for (int k = 0; k < R; k++) d = put(d, k, 1, 4'd5);   // inverse of var_in[2]
         run_case(d, 4'b1011, "R1", "R1");
         for (int k = 0; k < R; k++) d = put(d, k, 1, 4'd10);  // index 5: off
         run_case(d, 4'b1111, "R1", "R1");
         for (int k = 0; k < R; k++) d = put(d, k, 1, 4'd13);  // index 6 inverted: off
         run_case(d, 4'b0000, "R1", "R1");
      end

      // serpentine: slowest propagation
      snake = fill(K_OFF);
      for (int k = 0; k < C; k++) snake = put(snake, 0, k, K_ON);
      snake = put(snake, 1, C-1, K_ON);
      for (int k = 0; k < C; k++) snake = put(snake, 2, k, K_ON);
      run_case(snake, '0, "R3", "R4");

      // outputs hold while inputs wander (R6)
      begin
         bit hf, hg;
         hf = top_bottom;
         hg = left_right;
         repeat (6) begin
            @(negedge clk);
            lit_codes = fill(K_OFF);
            var_in    = NV'($urandom);
            check(done == 1'b0, "R6", "no done while idle", int'(done), 0);
         end
         check(top_bottom == hf, "R6", "hold top_bottom", int'(top_bottom), int'(hf));
         check(left_right == hg, "R6", "hold left_right", int'(left_right), int'(hg));
      end

      // start while running is ignored (R7)
      begin
         bit ef, eg;
         int el, n, extra;
         model(snake, '0, ef, eg, el);
         @(negedge clk);
         lit_codes = snake;
         var_in    = '0;
         start     = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         start     = 1'b1;
         lit_codes = fill(K_OFF);
         @(negedge clk);
         start = 1'b0;
         n = 2;
         if (!done) begin
            int m;
            wait_done(m);
            n += m;
         end
         check(n == el, "R7", "latency unaffected", n, el);
         check(top_bottom == ef, "R7", "busy start top_bottom", int'(top_bottom), int'(ef));
         check(left_right == eg, "R7", "busy start left_right", int'(left_right), int'(eg));
         extra = 0;
         repeat (N + 2) begin
            @(negedge clk);
            if (done) extra++;
         end
         check(extra == 0, "R7", "no extra done", extra, 0);
      end

      // start in the done cycle is accepted; old results hold one more cycle (R7)
      begin
         int n;
         @(negedge clk);
         lit_codes = snake;
         start     = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done(n);
         check(top_bottom == 1'b1 && left_right == 1'b1, "R7", "first result",
               int'({top_bottom, left_right}), 3);
         start     = 1'b1;
         lit_codes = fill(K_OFF);
         @(negedge clk);
         start = 1'b0;
         check(done == 1'b0, "R7", "gap after done", int'(done), 0);
         check(top_bottom == 1'b1 && left_right == 1'b1, "R6", "old result held",
               int'({top_bottom, left_right}), 3);
         @(negedge clk);
         check(done == 1'b1, "R7", "back-to-back done", int'(done), 1);
         check(top_bottom == 1'b0 && left_right == 1'b0, "R7", "second result",
               int'({top_bottom, left_right}), 0);
      end

      // constrained random grids
      repeat (300) begin
         logic [NB-1:0] l;
         for (int s = 0; s < N; s++) begin
            if ($urandom_range(2) == 0) l[s*LW +: LW] = K_ON;
            else l[s*LW +: LW] = LW'($urandom);
         end
         run_case(l, NV'($urandom), "R3", "R4");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule